// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Sequencer

This block is the device-side command logic of a serial NOR flash that is reached over a SPI slave port. It oversamples the serial clock, chip select and data-in lines with the core clock. It recognises three commands: set the write-enable latch, erase a sector, and read the status byte. It holds the write-enable latch and a busy flag, and it takes the three block-protect bits from the stored configuration input `prot_bits`.

An erase is accepted only when four conditions all hold. The frame must carry exactly one command byte and three address bytes. Chip select must rise right after the last address bit. The latch must already be set. All protect bits must be zero. When the erase is accepted, the block emits a one-cycle `erase_start` pulse with the sector index taken from address bits 23:16 (64 KiB sectors). It then stays busy for `ERASE_CYCLES` core clocks.

The sequencer states are:
- OPC: receiving the command byte.
- ADDR: receiving the address.
- ARMED: the 32nd bit has been taken and the block waits for chip select to rise.
- WEN: a write-enable byte is complete.
- STAT: the status byte is being shifted out.
- SKIP: the rest of the frame is ignored.

The transitions are:
- OPC goes to STAT, WEN, ADDR or SKIP on the eighth bit, depending on the opcode and the busy flag.
- ADDR goes to ARMED on the 32nd bit.
- ARMED and WEN go to SKIP on any further clock rise.
- Any state returns to OPC when chip select rises.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, `so_en`, `erase_start` and `busy` are 0, and a status read returns 0x00 while `prot_bits` is 0.
- R2: A frame carrying exactly the byte 0x06, ended by chip select rising after its eighth bit, sets the write-enable latch (status bit 1).
- R3: A frame of 0xD8 plus a 24-bit address, sent MSB first, raises `erase_start` for exactly one clock and sets `erase_sector` to address bits 23:16. The frame must end with chip select rising right after bit 32, with the latch set and `prot_bits` zero.
- R4: An erase frame sent while the write-enable latch is 0 produces no `erase_start`, and `busy` stays 0.
- R5: An erase frame whose chip select rises after 31 or after 40 bits is discarded, and the write-enable latch keeps its value.
- R6: With any `prot_bits` bit set, an erase frame is ignored. Status bits 4:2 report `prot_bits`.
- R7: `busy` (status bit 0) is 1 for exactly `ERASE_CYCLES` clocks, starting the clock after `erase_start`, and is then 0.
- R8: The write-enable latch reads 0 while the erase runs.
- R9: While busy is 1, write-enable and erase frames are ignored. Only the status read is served.
- R10: Opcode 0x05 makes SO shift out the status byte {000, prot_bits, latch, busy}, MSB first, one bit per SCK falling edge. The byte repeats while chip select stays low. `so_en` is 0 during command and address phases and while chip select is high.
- R11: Frames work the same whether SCK idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| prot_bits | input | 3 | Stored block-protect bits |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for SO; 0 means high impedance |
| erase_start | output | 1 | One-cycle pulse that starts a sector erase |
| erase_sector | output | 8 | Index of the sector being erased |
| busy | output | 1 | Erase in progress |

## Verification
Two kinds of internal fault become visible at the next status read, which shows every bit of latch and busy state within 16 SCK periods. A wrong latch value or a busy count that is off by one is caught this way. A wrong sequencer state shows up differently: an erase-start pulse appears, or fails to appear, a few core clocks after chip select rises. The bench therefore pairs each erase frame with a pulse count, and it reads status both during and after the busy window. It also counts the busy cycles directly.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_SE   = 8'h D8;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_ARMED = 3'd2,
        ST_WEN   = 3'd3,
        ST_STAT  = 3'd4,
        ST_SKIP  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/fe_spi_shift.sv
module fe_spi_shift #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             si,
    output logic             bit_rise,
    output logic             bit_fall,
    output logic             byte_done,
    output logic             frame_end,
    output logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] bit_cnt
);
    logic sck_q, cs_q;
    logic rise_c, fall_c;

    assign rise_c = sck & ~sck_q & ~cs_n;
    assign fall_c = ~sck & sck_q & ~cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
            bit_rise  <= 1'b0;
            bit_fall  <= 1'b0;
            byte_done <= 1'b0;
            frame_end <= 1'b0;
            rx_byte   <= '0;
            bit_cnt   <= '0;
        end else begin
            sck_q     <= sck;
            cs_q      <= cs_n;
            bit_rise  <= rise_c;
            bit_fall  <= fall_c;
            frame_end <= cs_n & ~cs_q;
            byte_done <= rise_c && (bit_cnt[2:0] == 3'd7);
            if (cs_n)
                bit_cnt <= '0;
            else if (rise_c && (bit_cnt != '1))
                bit_cnt <= bit_cnt + 1'b1;
            if (rise_c)
                rx_byte <= {rx_byte[6:0], si};
        end
    end
endmodule

// File: rtl/fe_cmd_fsm.sv
module fe_cmd_fsm
    import flash_erase_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic              bit_rise,
    input  logic              frame_end,
    input  logic [7:0]        rx_byte,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [2:0]        prot_bits,
    input  logic              busy,
    output logic              in_stat,
    output logic              wel,
    output logic              erase_start,
    output logic [SECT_W-1:0] erase_sector
);
    localparam int FRAME_BITS = 32;
    localparam int SECT_AT    = 16;

    seq_state_t state, nx;
    logic [SECT_W-1:0] sect_q;
    logic accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPC;
        else        state <= nx;
    end

    always_comb begin
        nx = state;
        unique case (state)
            ST_OPC: if (byte_done) begin
                if (rx_byte == OP_RDSR)               nx = ST_STAT;
                else if (rx_byte == OP_WREN && !busy) nx = ST_WEN;
                else if (rx_byte == OP_SE && !busy)   nx = ST_ADDR;
                else                                  nx = ST_SKIP;
            end
            ST_ADDR:  if (byte_done && bit_cnt == CNT_W'(FRAME_BITS)) nx = ST_ARMED;
            ST_ARMED: if (bit_rise) nx = ST_SKIP;
            ST_WEN:   if (bit_rise) nx = ST_SKIP;
            ST_STAT:  nx = ST_STAT;
            ST_SKIP:  nx = ST_SKIP;
            default:  nx = ST_SKIP;
        endcase
        if (frame_end) nx = ST_OPC;
    end

    assign accept  = frame_end && (state == ST_ARMED) && wel
                     && (prot_bits == 3'b000) && !busy;
    assign in_stat = (state == ST_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel          <= 1'b0;
            erase_start  <= 1'b0;
            erase_sector <= '0;
            sect_q       <= '0;
        end else begin
            erase_start <= accept;
            if (byte_done && state == ST_ADDR && bit_cnt == CNT_W'(SECT_AT))
                sect_q <= rx_byte[SECT_W-1:0];
            if (accept)
                erase_sector <= sect_q;
            if (accept)
                wel <= 1'b0;
            else if (frame_end && state == ST_WEN)
                wel <= 1'b1;
        end
    end
endmodule

// File: rtl/fe_busy_timer.sv
module fe_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int W = $clog2(CYCLES + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= W'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/fe_so_drive.sv
module fe_so_drive (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_stat,
    input  logic       bit_fall,
    input  logic [7:0] status,
    output logic       so,
    output logic       so_en
);
    logic [2:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so    <= 1'b0;
            so_en <= 1'b0;
            idx   <= '0;
        end else if (!in_stat) begin
            so    <= 1'b0;
            so_en <= 1'b0;
            idx   <= '0;
        end else if (bit_fall) begin
            so    <= status[3'd7 - idx];
            so_en <= 1'b1;
            idx   <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
    parameter int ERASE_CYCLES = 1000,
    parameter int SECT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic [2:0]        prot_bits,
    output logic              so,
    output logic              so_en,
    output logic              erase_start,
    output logic [SECT_W-1:0] erase_sector,
    output logic              busy
);
    localparam int CNT_W = 6;

    logic bit_rise, bit_fall, byte_done, frame_end;
    logic [7:0] rx_byte;
    logic [CNT_W-1:0] bit_cnt;
    logic in_stat, wel;
    logic [7:0] status;

    assign status = {3'b000, prot_bits, wel, busy};

    fe_spi_shift #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .bit_rise(bit_rise), .bit_fall(bit_fall), .byte_done(byte_done),
        .frame_end(frame_end), .rx_byte(rx_byte), .bit_cnt(bit_cnt)
    );

    fe_cmd_fsm #(.CNT_W(CNT_W), .SECT_W(SECT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .bit_rise(bit_rise),
        .frame_end(frame_end), .rx_byte(rx_byte), .bit_cnt(bit_cnt),
        .prot_bits(prot_bits), .busy(busy), .in_stat(in_stat), .wel(wel),
        .erase_start(erase_start), .erase_sector(erase_sector)
    );

    fe_busy_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(erase_start), .busy(busy)
    );

    fe_so_drive u_so (
        .clk(clk), .rst_n(rst_n), .in_stat(in_stat), .bit_fall(bit_fall),
        .status(status), .so(so), .so_en(so_en)
    );
endmodule

// File: rtl/fe_erase_chk.sv
module fe_erase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [2:0] prot_bits,
    input logic       erase_start,
    input logic       busy,
    input logic       wel,
    input logic       so_en
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start); // R3
    AST_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wel)); // R4
    AST_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> cs_n); // R5
    AST_NOT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (prot_bits == 3'b000)); // R6
    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> busy); // R7
    AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> !wel); // R8
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !erase_start); // R9
    AST_SO_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_en); // R10
endmodule

bind flash_erase_ctrl fe_erase_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prot_bits(prot_bits),
    .erase_start(erase_start), .busy(busy), .wel(wel), .so_en(so_en)
);

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb;
    localparam int EC   = 600;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic [2:0] prot_bits = 3'b000;
    logic so, so_en, erase_start, busy;
    logic [7:0] erase_sector;

    int checks = 0, errors = 0;
    int starts = 0, busy_cycles = 0;
    bit so_seen = 0, done = 0;

    always #4 clk = ~clk;

    flash_erase_ctrl #(.ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .prot_bits(prot_bits), .so(so), .so_en(so_en),
        .erase_start(erase_start), .erase_sector(erase_sector), .busy(busy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (erase_start) starts++;
            if (busy) busy_cycles++;
            if (!cs_n && so_en) so_seen = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [39:0] data, input int nbits, input bit mode3,
                         output logic [15:0] rx);
        rx = '0;
        so_seen = 0;
        sck = mode3;
        wclk(HALF);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0;
            si  = data[39 - i];
            wclk(HALF);
            rx  = {rx[14:0], so};
            sck = 1'b1;
            wclk(HALF);
        end
        if (!mode3) begin
            sck = 1'b0;
            wclk(HALF);
        end
        cs_n = 1'b1;
        wclk(3 * HALF);
    endtask

    task automatic rd_status(input bit mode3, output logic [7:0] st);
        logic [15:0] rx;
        frame({8'h05, 32'h0}, 16, mode3, rx);
        st = rx[7:0];
    endtask

    task automatic t_reset();
        logic [7:0] st;
        chk(so_en == 1'b0, "R1 so_en", so_en, 0);
        chk(erase_start == 1'b0, "R1 erase_start", erase_start, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        rd_status(0, st);
        chk(st == 8'h00, "R1 status", st, 8'h00);
    endtask

    task automatic t_no_wel();
        logic [15:0] rx;
        frame({8'hD8, 24'h123456, 8'h0}, 32, 0, rx);
        wclk(4);
        chk(starts == 0, "R4 start without latch", starts, 0);
        chk(busy == 1'b0, "R4 busy", busy, 0);
    endtask

    task automatic t_wren_and_repeat();
        logic [15:0] rx;
        frame({8'h06, 32'h0}, 8, 0, rx);
        frame({8'h05, 32'h0}, 24, 0, rx);
        chk(rx[7:0] == 8'h02, "R2 latch set", rx[7:0], 8'h02);
        chk(rx[15:8] == rx[7:0], "R10 status repeats", rx[15:8], rx[7:0]);
    endtask

    task automatic t_bad_length();
        logic [15:0] rx;
        logic [7:0] st;
        frame({8'hD8, 24'h220000, 8'h0}, 31, 0, rx);
        frame({8'hD8, 24'h330000, 8'hFF}, 40, 0, rx);
        chk(starts == 0, "R5 misaligned frames", starts, 0);
        rd_status(0, st);
        chk(st == 8'h02, "R5 latch kept", st, 8'h02);
    endtask

    task automatic t_protect();
        logic [15:0] rx;
        logic [7:0] st;
        prot_bits = 3'b010;
        frame({8'hD8, 24'h440000, 8'h0}, 32, 0, rx);
        chk(starts == 0, "R6 protected erase", starts, 0);
        rd_status(0, st);
        chk(st == 8'h0A, "R6 status protect field", st, 8'h0A);
        prot_bits = 3'b000;
    endtask

    task automatic t_erase();
        logic [15:0] rx;
        logic [7:0] st;
        busy_cycles = 0;
        frame({8'hD8, 24'h5A1234, 8'h0}, 32, 0, rx);
        chk(so_seen == 0, "R10 SO idle in address phase", so_seen, 0);
        chk(starts == 1, "R3 single pulse", starts, 1);
        chk(erase_sector == 8'h5A, "R3 sector index", erase_sector, 8'h5A);
        chk(busy == 1'b1, "R7 busy high", busy, 1);
        rd_status(0, st);
        chk(st == 8'h01, "R8 latch clear, busy set", st, 8'h01);
        frame({8'h06, 32'h0}, 8, 0, rx);
        frame({8'hD8, 24'h110000, 8'h0}, 32, 0, rx);
        chk(starts == 1, "R9 erase ignored while busy", starts, 1);
        chk(erase_sector == 8'h5A, "R9 sector unchanged", erase_sector, 8'h5A);
        wclk(EC);
        chk(busy_cycles == EC, "R7 busy length", busy_cycles, EC);
        rd_status(0, st);
        chk(st == 8'h00, "R9 write enable ignored while busy", st, 8'h00);
    endtask

    task automatic t_mode3();
        logic [15:0] rx;
        logic [7:0] st;
        frame({8'h06, 32'h0}, 8, 1, rx);
        rd_status(1, st);
        chk(st == 8'h02, "R11 mode 3 write enable", st, 8'h02);
        frame({8'hD8, 24'hC3FFFF, 8'h0}, 32, 1, rx);
        chk(starts == 2, "R11 mode 3 erase", starts, 2);
        chk(erase_sector == 8'hC3, "R11 mode 3 sector", erase_sector, 8'hC3);
        rd_status(1, st);
        chk(st == 8'h01, "R11 mode 3 status", st, 8'h01);
        wclk(EC);
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        t_reset();
        t_no_wel();
        t_wren_and_repeat();
        t_bad_length();
        t_protect();
        t_erase();
        t_mode3();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule